// File: doc/BRIEF.md
# Bidirectional-Terminal Universal Shift Register

An eight-stage register that can hold, shift toward its last stage, shift toward its first stage, or capture a parallel word, chosen by a two-bit mode input and applied on the rising clock. An active-low asynchronous clear empties every stage at once. Stage A (bit 0) is the first stage and stage H (bit `WIDTH-1`) is the last. Each end of the register has its own serial input.

The parallel word enters and leaves through one set of shared terminals. Each terminal is modelled as three signals: data in, data out and an output-enable flag. Two active-low enables gate the output drive. The drive is also withdrawn while the mode is parallel load, so outside data can be captured without contention.

Two dedicated outputs always show stage A and stage H, whatever the terminal state. Two devices can be chained: the last-stage output of one device feeds the shift-toward-last serial input of the next. The first-stage output of the next device feeds the shift-toward-first serial input of the one before it.

Top module: `univ_shreg`

## Requirements
- R1: While `rst_ni` is low, every stage is zero, with no clock edge needed and whatever the mode. A clock edge during clear leaves the stages at zero.
- R2: `mode_i[1]` is the upper select bit. The code 2'b00 holds, so all stages keep their value across clock edges.
- R3: Code 2'b01 shifts toward the last stage: on a rising edge, `ser_r_i` enters bit 0 and bit k takes the old bit k-1.
- R4: Code 2'b10 shifts toward the first stage: on a rising edge, `ser_l_i` enters bit `WIDTH-1` and bit k takes the old bit k+1.
- R5: Code 2'b11 is parallel load: on a rising edge, bit k takes `pio_i[k]`.
- R6: If `oe_a_ni` or `oe_b_ni` is high, every bit of `pio_oe_o` is 0 and `pio_o` reads 0.
- R7: Releasing the terminals does not change shifting, loading, holding or clearing.
- R8: `end_a_o` always equals bit 0 and `end_h_o` always equals bit `WIDTH-1`, whatever the enables.
- R9: In mode 2'b11, `pio_oe_o` is all zero even when both enables are low.
- R10: Two chained devices act as one register of twice the length, in both shift directions.
- R11: With both enables low and a mode other than load, `pio_oe_o` is all ones and `pio_o` shows the stages. During clear, `pio_o` therefore reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | Mode select: bit 1 is the upper select bit |
| oe_a_ni | input | 1 | First output enable, active low |
| oe_b_ni | input | 1 | Second output enable, active low |
| ser_r_i | input | 1 | Serial input that enters bit 0 |
| ser_l_i | input | 1 | Serial input that enters bit WIDTH-1 |
| pio_i | input | WIDTH | Shared terminals, input side |
| pio_o | output | WIDTH | Shared terminals, output side |
| pio_oe_o | output | WIDTH | Drive enable for each terminal |
| end_a_o | output | 1 | Bit 0 of the register, always driven |
| end_h_o | output | 1 | Bit WIDTH-1 of the register, always driven |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the asynchronous clear and a clocked load. The clear is lowered in the middle of a cycle, after a full word has been loaded. A load edge is then applied while the clear is still low. The register must read zero at once and must still be zero after that edge.

The second pair is release of the terminals and shifting. Either enable is raised while shift edges run. The terminals must stay undriven, the end outputs must keep tracking, and the register must match the bench's model once the enables drop.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/shreg_cell.sv
module shreg_cell
  import univ_shreg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  from_lo_i,
  input  logic  from_hi_i,
  input  logic  par_i,
  output logic  q_o
);
  logic d;

  always_comb begin
    unique case (mode_i)
      MODE_SHR:  d = from_lo_i;
      MODE_SHL:  d = from_hi_i;
      MODE_LOAD: d = par_i;
      default:   d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/shreg_pad_ctrl.sv
module shreg_pad_ctrl
  import univ_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] pio_o,
  output logic [WIDTH-1:0] pio_oe_o
);
  logic drive;

  // load mode frees the terminals for incoming data
  assign drive = !oe_a_ni && !oe_b_ni && (mode_i != MODE_LOAD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pio_oe_o[i] = drive;
    assign pio_o[i]    = drive & q_i[i];
  end
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import univ_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] pio_i,
  output logic [WIDTH-1:0] pio_o,
  output logic [WIDTH-1:0] pio_oe_o,
  output logic             end_a_o,
  output logic             end_h_o
);
  localparam int MSB = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] state_q;

  assign mode = mode_e'(mode_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic lo, hi;
    if (i == 0) begin : g_first
      assign lo = ser_r_i;
    end else begin : g_inner_lo
      assign lo = state_q[i-1];
    end
    if (i == MSB) begin : g_last
      assign hi = ser_l_i;
    end else begin : g_inner_hi
      assign hi = state_q[i+1];
    end

    shreg_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .from_lo_i(lo),
      .from_hi_i(hi),
      .par_i    (pio_i[i]),
      .q_o      (state_q[i])
    );
  end

  shreg_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .mode_i  (mode),
    .q_i     (state_q),
    .pio_o   (pio_o),
    .pio_oe_o(pio_oe_o)
  );

  assign end_a_o = state_q[0];
  assign end_h_o = state_q[MSB];
endmodule

// File: rtl/univ_shreg_chk.sv
module univ_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             oe_a_ni,
  input logic             oe_b_ni,
  input logic             ser_r_i,
  input logic             ser_l_i,
  input logic [WIDTH-1:0] pio_i,
  input logic [WIDTH-1:0] pio_o,
  input logic [WIDTH-1:0] pio_oe_o,
  input logic             end_a_o,
  input logic             end_h_o,
  input logic [WIDTH-1:0] state_q
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) clr_zero_chk: assert (state_q == '0);
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(state_q));

  // R3
  shr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> state_q == {$past(state_q[WIDTH-2:0]), $past(ser_r_i)});

  // R4
  shl_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> state_q == {$past(ser_l_i), $past(state_q[WIDTH-1:1])});

  // R5
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> state_q == $past(pio_i));

  // R6
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_ni || oe_b_ni) |-> (pio_oe_o == '0 && pio_o == '0));

  // R9
  load_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> pio_oe_o == '0);

  // R8
  end_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_oe_o[0] |-> (end_a_o == pio_o[0] && end_h_o == pio_o[WIDTH-1]));

  // R11
  drive_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni && !oe_b_ni && mode_i != 2'b11) |-> pio_oe_o == '1);
endmodule

bind univ_shreg univ_shreg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/univ_shreg_bench.sv
module univ_shreg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic       ser_r = 1'b0, ser_l = 1'b0;
  logic [7:0] pio_a_in = '0, pio_b_in = '0;
  logic [7:0] a_pio, a_oe, b_pio, b_oe;
  logic       a_end_a, a_end_h, b_end_a, b_end_h;
  logic [15:0] model = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  univ_shreg u_univ_shreg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .ser_r_i(ser_r), .ser_l_i(b_end_a), .pio_i(pio_a_in), .pio_o(a_pio),
    .pio_oe_o(a_oe), .end_a_o(a_end_a), .end_h_o(a_end_h));

  univ_shreg u_dev_b (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .ser_r_i(a_end_h), .ser_l_i(ser_l), .pio_i(pio_b_in), .pio_o(b_pio),
    .pio_oe_o(b_oe), .end_a_o(b_end_a), .end_h_o(b_end_h));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock edge, with the model advanced from the requirements
  task automatic step();
    if (rst_n) begin
      case (mode)
        2'b01: model = {model[14:0], ser_r};
        2'b10: model = {ser_l, model[15:1]};
        2'b11: model = {pio_b_in, pio_a_in};
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
  endtask

  task automatic read_both(string req);
    mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
    #1;
    check({req, " dev0"}, a_pio, model[7:0]);
    check({req, " dev1"}, b_pio, model[15:8]);
  endtask

  task automatic t_reset();
    #12;
    check("R11 reset oe", a_oe, 8'hFF);
    check("R11 reset pio", a_pio, 8'h00);
    check("R1 reset ends", {a_end_a, a_end_h}, 2'b00);
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic t_load();
    mode = 2'b11; pio_a_in = 8'h96; pio_b_in = 8'h00;
    #1;
    check("R9 load floats", a_oe, 8'h00);
    step();
    read_both("R5 load");
    check("R8 ends after load", {a_end_a, a_end_h}, 2'b01);
  endtask

  task automatic t_shifts();
    mode = 2'b01; ser_r = 1'b1; step();
    read_both("R3 shift right");
    check("R3 value", a_pio, 8'h2D);
    mode = 2'b10; ser_l = 1'b0; step();
    read_both("R4 shift left");
    check("R4 value", a_pio, 8'h96);
  endtask

  task automatic t_hold();
    mode = 2'b00;
    for (int i = 0; i < 3; i++) begin
      ser_r = i[0]; ser_l = ~i[0]; pio_a_in = 8'h5A; step();
    end
    read_both("R2 hold");
  endtask

  task automatic t_enables();
    mode = 2'b00; oe_a_n = 1'b1; #1;
    check("R6 oe_a releases", {a_oe, a_pio}, 16'h0000);
    check("R8 ends while off", {a_end_a, a_end_h}, {model[0], model[7]});
    oe_a_n = 1'b0; oe_b_n = 1'b1; #1;
    check("R6 oe_b releases", {a_oe, a_pio}, 16'h0000);
    oe_a_n = 1'b1;
    mode = 2'b01; ser_r = 1'b0; step();
    ser_r = 1'b1; step();
    check("R8 ends track shift", {a_end_a, a_end_h}, {model[0], model[7]});
    check("R6 still off", a_oe, 8'h00);
    read_both("R7 shift while off");
  endtask

  task automatic t_clear_collide();
    mode = 2'b11; pio_a_in = 8'hFF; pio_b_in = 8'hFF; step();
    read_both("R5 full load");
    #3;
    rst_n = 1'b0; model = '0;
    #1;
    check("R1 async clear", a_pio, 8'h00);
    check("R11 clear reads low", b_pio, 8'h00);
    mode = 2'b11; pio_a_in = 8'hAA; oe_a_n = 1'b1;
    @(posedge clk); #2;
    oe_a_n = 1'b0; mode = 2'b00; #1;
    check("R1 clear beats load", a_pio, 8'h00);
    @(posedge clk); #2;
    rst_n = 1'b1;
    read_both("R1 after clear");
  endtask

  task automatic t_cascade();
    logic [15:0] pat = 16'hC35A;
    mode = 2'b01;
    for (int i = 15; i >= 0; i--) begin
      ser_r = pat[i]; step();
    end
    read_both("R10 chain right");
    check("R10 chain word", {b_pio, a_pio}, 16'hC35A);
    mode = 2'b10; ser_l = 1'b1;
    for (int i = 0; i < 4; i++) step();
    read_both("R10 chain left");
    check("R10 chain left word", {b_pio, a_pio}, 16'hFC35);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_shifts();
    t_hold();
    t_enables();
    t_clear_collide();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule